// File: doc/BRIEF.md
# Segment Playback Sequencer with Branching

This block drives the read address of a waveform sample memory, one address per sample clock. It holds a table of sequence entries. Each entry names a stored segment by start address and length, gives a repeat count, selects whether the sequencer moves on by itself or waits for an advance event, and may be marked as the last entry so the sequence wraps. Segments of consecutive entries are played back to back, so long outputs are built from short stored pieces that are used many times.

Two trigger kinds steer the playback. Each comes from a hardware pin with a programmable active edge or from a one-cycle software strobe. An advance event ends the current entry early, or releases an entry that is waiting. A branch event jumps to a target entry. The target is held in a branch vector table with one vector for each entry. Every recognised event passes through a fixed latency-matching delay line. It is then held pending and applied at the next segment boundary, so a segment is never cut off partway. The host loads both tables through a simple write port while the sequencer is stopped.

Top module: `seg_seq_top`

## Requirements
- R1: After reset `rdValid`, `wrError` and `curEntry` are 0. When `runEn` is sampled high while stopped, the next cycle shows `rdValid`=1, `curEntry`=0 and `rdAddr` equal to entry 0's start address.
- R2: An entry's segment is emitted as consecutive addresses start, start+1, …, start+L-1, where the length field holds L-1. The first address of the following segment comes in the very next cycle, and `rdValid` stays high.
- R3: An entry with repeat field n plays its segment n+1 times in a row (0 means once) before the sequence moves on.
- R4: After an entry whose last flag is set, playback continues at entry 0. Otherwise it continues at the next index.
- R5: An entry with its wait flag set replays its segment, after its repeats are used, until an advance is pending. A pending advance moves to the next entry at the next boundary, even if repeats remain.
- R6: A pending branch at a boundary loads the entry named by the branch vector stored for the current entry. A branch takes priority over an advance that is pending at the same boundary.
- R7: A hardware trigger is recognised on a rising edge when its polarity bit is 0 and on a falling edge when it is 1. The opposite edge has no effect. A software strobe is recognised in the cycle it is high. Events are recognised only while running.
- R8: A recognised event is applied at the first segment boundary that falls at least `TRIG_LAT`+1 clocks after recognition (default 256). The switch happens only after the last address of the current segment.
- R9: Write data layout: bits [ADDR_W-1:0] hold the start address, followed upward by the length-minus-one field (LEN_W bits), the repeat field (REP_W bits), the wait flag and, at the top, the last flag. `wrSel`=0 writes the sequence table and `wrSel`=1 writes the branch vector (the low IDX_W bits of `wrData`) of entry `wrIdx`.
- R10: A write while running is ignored, and `wrError` is high for exactly one cycle after it. A write while stopped does not raise `wrError`.
- R11: When `runEn` is sampled low, `rdValid` is 0 in the next cycle and any pending or in-flight trigger events are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; the rising level starts at entry 0 |
| hwAdvance | input | 1 | Hardware advance trigger |
| hwBranch | input | 1 | Hardware branch trigger |
| swAdvance | input | 1 | Software advance strobe |
| swBranch | input | 1 | Software branch strobe |
| advPolarity | input | 1 | Advance active edge: 0 rising, 1 falling |
| brPolarity | input | 1 | Branch active edge: 0 rising, 1 falling |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 1 | 0 sequence table, 1 branch vector table |
| wrIdx | input | IDX_W | Entry index to write |
| wrData | input | ADDR_W+LEN_W+REP_W+2 | Entry or branch vector contents |
| rdAddr | output | ADDR_W | Waveform memory read address |
| rdValid | output | 1 | Address is valid (sequencer running) |
| curEntry | output | IDX_W | Index of the entry being played |
| wrError | output | 1 | One-cycle flag for a write that was ignored |

## Verification
On every cycle the assertions check several properties: addresses rise by one inside a segment; the entry index changes only at a boundary; a branch lands on the stored vector; the control issues at most one step decision per cycle; every rejected write raises the error flag; and nothing stays pending while stopped. Only the bench scenarios can show the whole address stream with its repeats and wrap, that the trigger latency falls inside the expected window, that the active edge follows the polarity, that a branch wins over an advance, and that a write made while running leaves the table unchanged after a restart.

// File: rtl/seg_seq_pkg.sv
package seg_seq_pkg;
  // One-hot step decisions passed from control to datapath
  typedef struct packed {
    logic start;   // load entry 0
    logic step;    // next sample inside the segment
    logic replay;  // replay segment, consume one repeat
    logic hold;    // replay segment while waiting for advance
    logic next;    // move to following entry
    logic branch;  // jump to branch vector
  } seqStb_t;
endpackage

// File: rtl/seg_seq_trig.sv
module seg_seq_trig #(
  parameter int TRIG_LAT = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic hwIn,
  input  logic swIn,
  input  logic pol,
  input  logic armed,
  input  logic consume,
  output logic pending
);
  localparam int LAT = (TRIG_LAT < 2) ? 2 : TRIG_LAT;

  logic rawQ;
  logic raw;
  logic ev;
  logic [LAT-1:0] line;

  assign raw = hwIn ^ pol;
  assign ev  = armed & ((raw & ~rawQ) | swIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ    <= 1'b0;
      line    <= '0;
      pending <= 1'b0;
    end else begin
      rawQ <= raw;
      if (!armed) begin
        line    <= '0;
        pending <= 1'b0;
      end else begin
        line    <= {line[LAT-2:0], ev};
        pending <= line[LAT-1] | (pending & ~consume);
      end
    end
  end

  AST_TRIG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !pending); // R11
endmodule

// File: rtl/seg_seq_ctrl.sv
module seg_seq_ctrl import seg_seq_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    runEn,
  input  logic    atEnd,
  input  logic    repZero,
  input  logic    curWait,
  input  logic    advPend,
  input  logic    brPend,
  input  logic    wrEn,
  output seqStb_t stb,
  output logic    running,
  output logic    advUse,
  output logic    brUse,
  output logic    wrError
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      wrError <= 1'b0;
    end else begin
      running <= runEn;
      wrError <= wrEn & running;
    end
  end

  always_comb begin
    stb    = '0;
    advUse = 1'b0;
    brUse  = 1'b0;
    if (runEn && !running) begin
      stb.start = 1'b1;
    end else if (runEn && running) begin
      if (!atEnd) begin
        stb.step = 1'b1;
      end else if (brPend) begin
        stb.branch = 1'b1;
        brUse      = 1'b1;
      end else if (advPend) begin
        stb.next = 1'b1;
        advUse   = 1'b1;
      end else if (!repZero) begin
        stb.replay = 1'b1;
      end else if (curWait) begin
        stb.hold = 1'b1;
      end else begin
        stb.next = 1'b1;
      end
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R6
  AST_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && running) |=> wrError); // R10
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !running); // R11
endmodule

// File: rtl/seg_seq_dp.sv
module seg_seq_dp import seg_seq_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int REP_W  = 8,
  parameter int IDX_W  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  seqStb_t                          stb,
  input  logic                             wrAccept,
  input  logic                             wrSel,
  input  logic [IDX_W-1:0]                 wrIdx,
  input  logic [ADDR_W+LEN_W+REP_W+1:0]    wrData,
  output logic [ADDR_W-1:0]                rdAddr,
  output logic [IDX_W-1:0]                 curIdx,
  output logic                             atEnd,
  output logic                             repZero,
  output logic                             curWait
);
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic              last;
    logic              waitAdv;
    logic [REP_W-1:0]  rep;
    logic [LEN_W-1:0]  lenM1;
    logic [ADDR_W-1:0] start;
  } entry_t;

  entry_t           seqTab [DEPTH];
  logic [IDX_W-1:0] brTab  [DEPTH];

  logic [LEN_W-1:0] offset;
  logic [REP_W-1:0] repLeft;
  entry_t           cur;
  entry_t           loadEnt;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] brTarget;
  logic [IDX_W-1:0] loadIdx;
  logic             doLoad;

  assign cur      = seqTab[curIdx];
  assign nextIdx  = cur.last ? '0 : curIdx + 1'b1;
  assign brTarget = brTab[curIdx];
  assign doLoad   = stb.start | stb.next | stb.branch;

  always_comb begin
    if (stb.start)       loadIdx = '0;
    else if (stb.branch) loadIdx = brTarget;
    else                 loadIdx = nextIdx;
  end

  assign loadEnt = seqTab[loadIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= '0;
      offset  <= '0;
      repLeft <= '0;
    end else if (doLoad) begin
      curIdx  <= loadIdx;
      offset  <= '0;
      repLeft <= loadEnt.rep;
    end else if (stb.step) begin
      offset <= offset + 1'b1;
    end else if (stb.replay) begin
      offset  <= '0;
      repLeft <= repLeft - 1'b1;
    end else if (stb.hold) begin
      offset <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wrAccept) begin
      if (wrSel) brTab[wrIdx]  <= wrData[IDX_W-1:0];
      else       seqTab[wrIdx] <= wrData;
    end
  end

  assign atEnd   = (offset == cur.lenM1);
  assign repZero = (repLeft == '0);
  assign curWait = cur.waitAdv;
  assign rdAddr  = cur.start + ADDR_W'(offset);

  AST_SAMPLE_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> rdAddr == $past(rdAddr) + 1'b1); // R2
  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> $stable(curIdx)); // R8
  AST_OFFSET_IN_SEG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step || stb.replay || stb.hold || stb.next || stb.branch) |-> offset <= cur.lenM1); // R8
  AST_BRANCH_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    stb.branch |=> curIdx == $past(brTarget)); // R6
endmodule

// File: rtl/seg_seq_top.sv
module seg_seq_top import seg_seq_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 8,
  parameter int REP_W    = 8,
  parameter int IDX_W    = 8,
  parameter int TRIG_LAT = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          runEn,
  input  logic                          hwAdvance,
  input  logic                          hwBranch,
  input  logic                          swAdvance,
  input  logic                          swBranch,
  input  logic                          advPolarity,
  input  logic                          brPolarity,
  input  logic                          wrEn,
  input  logic                          wrSel,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [ADDR_W+LEN_W+REP_W+1:0] wrData,
  output logic [ADDR_W-1:0]             rdAddr,
  output logic                          rdValid,
  output logic [IDX_W-1:0]              curEntry,
  output logic                          wrError
);
  seqStb_t stb;
  logic running, atEnd, repZero, curWait;
  logic advPend, brPend, advUse, brUse;

  seg_seq_trig #(.TRIG_LAT(TRIG_LAT)) u_advTrig (
    .clk(clk), .rstN(rstN), .hwIn(hwAdvance), .swIn(swAdvance),
    .pol(advPolarity), .armed(running), .consume(advUse), .pending(advPend));

  seg_seq_trig #(.TRIG_LAT(TRIG_LAT)) u_brTrig (
    .clk(clk), .rstN(rstN), .hwIn(hwBranch), .swIn(swBranch),
    .pol(brPolarity), .armed(running), .consume(brUse), .pending(brPend));

  seg_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .atEnd(atEnd), .repZero(repZero),
    .curWait(curWait), .advPend(advPend), .brPend(brPend), .wrEn(wrEn),
    .stb(stb), .running(running), .advUse(advUse), .brUse(brUse),
    .wrError(wrError));

  seg_seq_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REP_W(REP_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAccept(wrEn & ~running),
    .wrSel(wrSel), .wrIdx(wrIdx), .wrData(wrData), .rdAddr(rdAddr),
    .curIdx(curEntry), .atEnd(atEnd), .repZero(repZero), .curWait(curWait));

  assign rdValid = running;
endmodule

// File: tb/seg_seq_top_tb.sv
module seg_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 256;
  localparam int EW  = 34;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, hwAdvance = 0, hwBranch = 0, swAdvance = 0, swBranch = 0;
  logic advPolarity = 0, brPolarity = 0, wrEn = 0, wrSel = 0;
  logic [7:0] wrIdx = '0;
  logic [EW-1:0] wrData = '0;
  logic [15:0] rdAddr;
  logic rdValid, wrError;
  logic [7:0] curEntry;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seg_seq_top u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .hwAdvance(hwAdvance),
    .hwBranch(hwBranch), .swAdvance(swAdvance), .swBranch(swBranch),
    .advPolarity(advPolarity), .brPolarity(brPolarity), .wrEn(wrEn),
    .wrSel(wrSel), .wrIdx(wrIdx), .wrData(wrData), .rdAddr(rdAddr),
    .rdValid(rdValid), .curEntry(curEntry), .wrError(wrError));

  // Expected address stream for the first programme (R2, R3, R4)
  localparam logic [15:0] STREAM [22] = '{
    16'h100, 16'h101, 16'h102, 16'h100, 16'h101, 16'h102, 16'h200, 16'h201,
    16'h300, 16'h300, 16'h300,
    16'h100, 16'h101, 16'h102, 16'h100, 16'h101, 16'h102, 16'h200, 16'h201,
    16'h300, 16'h300, 16'h300};

  function automatic logic [EW-1:0] mkEnt(logic [15:0] st, logic [7:0] lm1,
                                          logic [7:0] rep, logic w, logic l);
    return {l, w, rep, lm1, st};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] idx, logic [EW-1:0] d);
    wrSel = sel; wrIdx = idx; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Counts clocks until curEntry leaves oldEnt; reports last address before it
  task automatic waitSwitch(logic [7:0] oldEnt, output int n, output logic [15:0] prevAddr);
    n = 0;
    prevAddr = rdAddr;
    while (curEntry == oldEnt && n < 600) begin
      prevAddr = rdAddr;
      @(negedge clk);
      swAdvance = 1'b0; swBranch = 1'b0;
      n++;
    end
  endtask

  initial begin
    int n;
    logic [15:0] pa;
    tick(3);
    // R1 reset state
    check("R1 rdValid after reset", 32'(rdValid), 0);
    check("R1 wrError after reset", 32'(wrError), 0);
    check("R1 curEntry after reset", 32'(curEntry), 0);
    rstN = 1'b1;
    tick(1);

    // R9 program table while stopped
    wr(0, 0, mkEnt(16'h100, 8'd2, 8'd1, 0, 0));
    check("R10 no error on stopped write", 32'(wrError), 0);
    wr(0, 1, mkEnt(16'h200, 8'd1, 8'd0, 0, 0));
    wr(0, 2, mkEnt(16'h300, 8'd0, 8'd2, 0, 1));

    runEn = 1'b1;
    tick(1);
    check("R1 first address is entry 0 start", 32'(rdAddr), 32'h100);
    for (int i = 0; i < 22; i++) begin
      check("R2 R3 R4 stream address", 32'(rdAddr), 32'(STREAM[i]));
      check("R2 valid without gap", 32'(rdValid), 1);
      tick(1);
    end

    // R10 write while running
    wrSel = 0; wrIdx = 0; wrData = mkEnt(16'h700, 8'd0, 8'd0, 0, 0); wrEn = 1'b1;
    tick(1);
    wrEn = 1'b0;
    check("R10 error flag after running write", 32'(wrError), 1);
    tick(1);
    check("R10 error flag lasts one cycle", 32'(wrError), 0);

    // R11 stop
    runEn = 1'b0;
    tick(1);
    check("R11 rdValid low after stop", 32'(rdValid), 0);
    runEn = 1'b1;
    tick(1);
    check("R10 ignored write left entry 0 intact", 32'(rdAddr), 32'h100);
    runEn = 1'b0;
    tick(2);

    // R5 R8 wait and software advance
    wr(0, 0, mkEnt(16'h400, 8'd3, 8'd0, 1, 0));
    wr(0, 1, mkEnt(16'h500, 8'd3, 8'd0, 0, 1));
    runEn = 1'b1;
    tick(100);
    check("R5 waiting entry holds", 32'(curEntry), 0);
    swAdvance = 1'b1;
    waitSwitch(8'd0, n, pa);
    check("R8 advance latency window", 32'(n >= LAT + 2 && n <= LAT + 5), 1);
    check("R8 segment finished before switch", 32'(pa), 32'h403);
    check("R5 advance lands on next entry", 32'(rdAddr), 32'h500);
    check("R5 next entry index", 32'(curEntry), 1);
    tick(4);
    check("R4 last entry wraps to 0", 32'(curEntry), 0);

    // R11 pending discarded on stop
    tick(3);
    swAdvance = 1'b1;
    tick(1);
    swAdvance = 1'b0;
    runEn = 1'b0;
    tick(2);
    runEn = 1'b1;
    tick(300);
    check("R11 stop discards in-flight advance", 32'(curEntry), 0);
    runEn = 1'b0;
    tick(2);

    // R7 falling-edge polarity on hardware advance
    advPolarity = 1'b1;
    tick(2);
    runEn = 1'b1;
    tick(10);
    hwAdvance = 1'b1;
    tick(300);
    check("R7 inactive edge ignored", 32'(curEntry), 0);
    hwAdvance = 1'b0;
    waitSwitch(8'd0, n, pa);
    check("R7 active falling edge advances", 32'(curEntry), 1);
    check("R8 hardware advance latency window", 32'(n >= LAT + 2 && n <= LAT + 5), 1);
    runEn = 1'b0;
    advPolarity = 1'b0;
    tick(2);

    // R6 branch beats advance
    wr(1, 0, EW'(2));
    wr(0, 2, mkEnt(16'h600, 8'd1, 8'd0, 0, 1));
    runEn = 1'b1;
    tick(20);
    swBranch = 1'b1; swAdvance = 1'b1;
    waitSwitch(8'd0, n, pa);
    check("R6 branch target entry", 32'(curEntry), 2);
    check("R6 branch target address", 32'(rdAddr), 32'h600);
    check("R8 branch latency window", 32'(n >= LAT + 2 && n <= LAT + 5), 1);
    tick(2);
    check("R4 wrap after branched last entry", 32'(curEntry), 0);
    runEn = 1'b0;
    tick(2);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule